// File: doc/BRIEF.md
# Input Buffer Swap Controller

This controller sits beside the five input buffers of a mesh router. When a buffer is marked as failed, the controller finds a healthy buffer that belongs to another input port. It lends that buffer to the port that lost its own, so no spare buffers are needed. Each swap runs through three states.

- **Idle.** Every port maps to its own buffer.
- **Drain.** A substitute is chosen. A one-cycle control token is sent to the neighbour on the substitute port, and its link is idled. The controller stays here until the traffic already in the substitute buffer has left.
- **Engage.** The port-to-buffer table is rewritten, and the link of the failed port is granted again. Its flits now go into the borrowed buffer.

After a swap, the two upstream routers that share a buffer are granted one at a time. Ownership passes only at packet boundaries, so their packets never mix.

The controller has two more handshake duties:

- It reports, per port, whether the port can accept traffic.
- It gates its own transmissions. When a neighbour sends it a control token, it stops launching flits on that link until the neighbour's grant drops.

Fault diagnosis, route computation and the buffers themselves belong to other blocks.

Top module: `buf_swap_ctrl`

## Requirements
- R1: After reset the following hold:
  - every map entry equals its own port index;
  - the state code is 0 (idle);
  - no token is sent and the no-substitute flag is low;
  - every port with a clear fault flag is granted;
  - `port_ok_o` equals the inverse of the fault flags.
- R2: A port is pending when its fault flag is set and it has not been swapped. In idle, the lowest-indexed pending port is chosen, and a substitute buffer is searched for.
  - The search runs in ascending ring order from the pending index (index+1, index+2, … wrapping modulo 5). Ports are 0 north, 1 east, 2 south, 3 west, 4 local.
  - A buffer is skipped when it is flagged faulty, already lent, or belongs to a swapped port.
  - If a substitute is found, the next cycle has state code 1 (drain). `ctl_tok_o` then carries a single bit at the substitute index for exactly that first drain cycle.
- R3: When a port is pending and no substitute exists, the state stays idle. `nosub_o` is high for as long as that condition holds.
- R4: In drain, the grants of the failed port and of the substitute port are both 0. A pending port is never granted in any state.
- R5: Drain moves to state code 2 (engage) on the clock edge where the substitute buffer's occupancy is zero and one of the following is true:
  - a tail flit leaves that buffer, or
  - it is the first drain cycle.
  Otherwise the state stays in drain.
- R6: When engage is entered, the following take effect together:
  - the failed port's map entry becomes the substitute index;
  - the failed port is granted and the substitute's home port is not.
  Engage returns to idle on an edge where the substitute occupancy is zero and either a tail flit leaves or the failed port's upstream request is low.
- R7: Outside an active swap, when two ports share a buffer, at most one of them is granted. Ownership passes to the other port on an edge where all of the following are true:
  - the buffer is empty;
  - the other port requests;
  - either a tail flit leaves the buffer, or the current owner does not request.
- R8: `port_ok_o[p]` is 1 when port p's fault flag is clear or port p has been swapped.
- R9: `tx_ok_o[p]` equals `ds_grant_i[p]` unless a hold is set for port p.
  - A hold is set by an edge that sees `ctl_tok_i[p]`.
  - It is cleared by an edge that sees `ds_grant_i[p]` low with no token.
- R10: Several failed ports are swapped one at a time, lowest index first. Each later search sees the buffers already lent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| fault_i | input | NPORT | Sticky failed-buffer flag per input port |
| occ_i | input | NPORT*OCCW | Occupancy count per buffer, buffer b at bits b*OCCW |
| tail_out_i | input | NPORT | A tail flit leaves buffer b this cycle |
| up_req_i | input | NPORT | Upstream router on link p has flits waiting |
| ctl_tok_i | input | NPORT | Control token from the neighbour on port p |
| ds_grant_i | input | NPORT | Grant from the downstream neighbour on port p |
| map_o | output | NPORT*IDXW | Buffer index used by input port p, at bits p*IDXW |
| grant_o | output | NPORT | Permission for the upstream router on link p to send |
| port_ok_o | output | NPORT | Input port p has a working buffer path |
| ctl_tok_o | output | NPORT | Control token to the neighbour on port p |
| tx_ok_o | output | NPORT | This router may launch flits on output p |
| nosub_o | output | 1 | A failed port waits and no substitute exists |
| state_o | output | 2 | Swap state: 0 idle, 1 drain, 2 engage |

## Verification
Several properties are checked on every cycle:
- two ports sharing one buffer are never granted together;
- a map entry never points at a flagged buffer;
- a pending port is never granted;
- tokens are one-hot and appear only in drain;
- the state only steps in the order idle, drain, engage;
- a received token blocks transmission on the following cycle.

Other behaviour only the bench can show. That covers the ring search order, the exact drain and release edges, the ownership hand-over of a shared buffer, and the order in which several faults are serviced. The bench compares all outputs every cycle against its reference model, under random occupancy, tail, request and token traffic.

// File: rtl/buf_swap_pkg.sv
package buf_swap_pkg;
  typedef enum logic [1:0] {
    SW_IDLE   = 2'd0,
    SW_DRAIN  = 2'd1,
    SW_ENGAGE = 2'd2
  } swap_st_e;
endpackage

// File: rtl/swap_pick.sv
// Chooses the pending failed port and a substitute buffer by ring search.
module swap_pick #(
  parameter int NPORT = 5,
  parameter int IDXW  = 3
) (
  input  logic [NPORT-1:0] fault_i,
  input  logic [NPORT-1:0] swapped_i,
  input  logic [NPORT-1:0] lent_i,
  output logic             pend_o,
  output logic [IDXW-1:0]  pend_idx_o,
  output logic             found_o,
  output logic [IDXW-1:0]  sub_idx_o
);
  logic            any_free;
  logic [IDXW-1:0] cand;
  int              c;

  always_comb begin
    pend_o     = 1'b0;
    pend_idx_o = '0;
    for (int p = NPORT - 1; p >= 0; p--) begin
      if (fault_i[p] && !swapped_i[p]) begin
        pend_o     = 1'b1;
        pend_idx_o = IDXW'(p);
      end
    end
  end

  always_comb begin
    any_free  = 1'b0;
    sub_idx_o = '0;
    cand      = '0;
    c         = 0;
    for (int k = NPORT - 1; k >= 1; k--) begin
      c = int'(pend_idx_o) + k;
      if (c >= NPORT) c = c - NPORT;
      cand = IDXW'(c);
      if (!fault_i[cand] && !lent_i[cand] && !swapped_i[cand]) begin
        any_free  = 1'b1;
        sub_idx_o = cand;
      end
    end
    found_o = pend_o && any_free;
  end
endmodule

// File: rtl/swap_seq.sv
// Three-state swap sequencer and the port-to-buffer table.
module swap_seq
  import buf_swap_pkg::*;
#(
  parameter int NPORT = 5,
  parameter int IDXW  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       pend_i,
  input  logic [IDXW-1:0]            pend_idx_i,
  input  logic                       found_i,
  input  logic [IDXW-1:0]            sub_idx_i,
  input  logic [NPORT-1:0]           occ_zero_i,
  input  logic [NPORT-1:0]           tail_i,
  input  logic [NPORT-1:0]           up_req_i,
  output swap_st_e                   st_o,
  output logic [IDXW-1:0]            fail_idx_o,
  output logic [IDXW-1:0]            sub_idx_o,
  output logic                       first_o,
  output logic                       engage_o,
  output logic [NPORT-1:0][IDXW-1:0] map_o,
  output logic [NPORT-1:0][IDXW-1:0] guest_o,
  output logic [NPORT-1:0]           swapped_o,
  output logic [NPORT-1:0]           lent_o
);
  swap_st_e                   st_q, st_d;
  logic [IDXW-1:0]            fr_q, br_q;
  logic                       first_q, first_d;
  logic                       start, drained, release_ok;
  logic [NPORT-1:0][IDXW-1:0] map_q, guest_q;
  logic [NPORT-1:0]           swapped_q, lent_q;

  assign start      = (st_q == SW_IDLE) && found_i;
  assign drained    = occ_zero_i[br_q] && (tail_i[br_q] || first_q);
  assign release_ok = occ_zero_i[br_q] && (tail_i[br_q] || !up_req_i[fr_q]);
  assign engage_o   = (st_q == SW_DRAIN) && drained;

  always_comb begin
    st_d    = st_q;
    first_d = 1'b0;
    unique case (st_q)
      SW_IDLE: begin
        if (start) begin
          st_d    = SW_DRAIN;
          first_d = 1'b1;
        end
      end
      SW_DRAIN:  if (drained) st_d = SW_ENGAGE;
      SW_ENGAGE: if (release_ok) st_d = SW_IDLE;
      default:   st_d = SW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= SW_IDLE;
      first_q <= 1'b0;
    end else begin
      st_q    <= st_d;
      first_q <= first_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fr_q <= '0;
      br_q <= '0;
    end else if (start) begin
      fr_q <= pend_idx_i;
      br_q <= sub_idx_i;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_tab
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        map_q[p]     <= IDXW'(p);
        guest_q[p]   <= '0;
        swapped_q[p] <= 1'b0;
        lent_q[p]    <= 1'b0;
      end else if (engage_o) begin
        if (fr_q == IDXW'(p)) begin
          map_q[p]     <= br_q;
          swapped_q[p] <= 1'b1;
        end
        if (br_q == IDXW'(p)) begin
          guest_q[p] <= fr_q;
          lent_q[p]  <= 1'b1;
        end
      end
    end
  end

  assign st_o       = st_q;
  assign fail_idx_o = fr_q;
  assign sub_idx_o  = br_q;
  assign first_o    = first_q;
  assign map_o      = map_q;
  assign guest_o    = guest_q;
  assign swapped_o  = swapped_q;
  assign lent_o     = lent_q;
endmodule

// File: rtl/swap_share.sv
// Per-buffer ownership between home port and guest port of a lent buffer.
module swap_share #(
  parameter int NPORT = 5,
  parameter int IDXW  = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [NPORT-1:0]           lent_i,
  input  logic [NPORT-1:0][IDXW-1:0] guest_i,
  input  logic [NPORT-1:0]           freeze_i,
  input  logic [NPORT-1:0]           load_i,
  input  logic [NPORT-1:0]           occ_zero_i,
  input  logic [NPORT-1:0]           tail_i,
  input  logic [NPORT-1:0]           up_req_i,
  output logic [NPORT-1:0]           guest_own_o
);
  for (genvar b = 0; b < NPORT; b++) begin : g_buf
    logic own_q, own_d, g_req, h_req, edge_ok;

    assign g_req   = up_req_i[guest_i[b]];
    assign h_req   = up_req_i[b];
    assign edge_ok = occ_zero_i[b];

    always_comb begin
      own_d = own_q;
      if (load_i[b]) begin
        own_d = 1'b1;
      end else if (lent_i[b] && !freeze_i[b] && edge_ok) begin
        if (own_q && h_req && (tail_i[b] || !g_req)) own_d = 1'b0;
        else if (!own_q && g_req && (tail_i[b] || !h_req)) own_d = 1'b1;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) own_q <= 1'b0;
      else        own_q <= own_d;
    end

    assign guest_own_o[b] = own_q;
  end
endmodule

// File: rtl/swap_hold.sv
// Holds off own transmissions after a neighbour's control token.
module swap_hold #(
  parameter int NPORT = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NPORT-1:0] tok_i,
  input  logic [NPORT-1:0] ds_grant_i,
  output logic [NPORT-1:0] tx_ok_o
);
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    logic hold_q, hold_d;

    always_comb begin
      hold_d = hold_q;
      if (tok_i[p])            hold_d = 1'b1;
      else if (!ds_grant_i[p]) hold_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) hold_q <= 1'b0;
      else        hold_q <= hold_d;
    end

    assign tx_ok_o[p] = ds_grant_i[p] && !hold_q;
  end
endmodule

// File: rtl/buf_swap_ctrl.sv
module buf_swap_ctrl
  import buf_swap_pkg::*;
#(
  parameter int NPORT = 5,
  parameter int OCCW  = 4,
  parameter int IDXW  = (NPORT > 1) ? $clog2(NPORT) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NPORT-1:0]      fault_i,
  input  logic [NPORT*OCCW-1:0] occ_i,
  input  logic [NPORT-1:0]      tail_out_i,
  input  logic [NPORT-1:0]      up_req_i,
  input  logic [NPORT-1:0]      ctl_tok_i,
  input  logic [NPORT-1:0]      ds_grant_i,
  output logic [NPORT*IDXW-1:0] map_o,
  output logic [NPORT-1:0]      grant_o,
  output logic [NPORT-1:0]      port_ok_o,
  output logic [NPORT-1:0]      ctl_tok_o,
  output logic [NPORT-1:0]      tx_ok_o,
  output logic                  nosub_o,
  output logic [1:0]            state_o
);
  logic                       pend, found;
  logic [IDXW-1:0]            pend_idx, pick_idx, fr, br;
  logic [NPORT-1:0]           occ_zero, swapped, lent, guest_own, freeze, load;
  logic [NPORT-1:0][IDXW-1:0] map_t, guest_t;
  logic                       first, engage;
  swap_st_e                   st;

  for (genvar b = 0; b < NPORT; b++) begin : g_occ
    assign occ_zero[b] = (occ_i[b*OCCW +: OCCW] == '0);
    assign freeze[b]   = (st != SW_IDLE) && (br == IDXW'(b));
    assign load[b]     = engage && (br == IDXW'(b));
  end

  swap_pick #(.NPORT(NPORT), .IDXW(IDXW)) u_pick (
    .fault_i(fault_i), .swapped_i(swapped), .lent_i(lent),
    .pend_o(pend), .pend_idx_o(pend_idx), .found_o(found), .sub_idx_o(pick_idx)
  );

  swap_seq #(.NPORT(NPORT), .IDXW(IDXW)) u_seq (
    .clk(clk), .rst_n(rst_n), .pend_i(pend), .pend_idx_i(pend_idx),
    .found_i(found), .sub_idx_i(pick_idx), .occ_zero_i(occ_zero),
    .tail_i(tail_out_i), .up_req_i(up_req_i), .st_o(st), .fail_idx_o(fr),
    .sub_idx_o(br), .first_o(first), .engage_o(engage), .map_o(map_t),
    .guest_o(guest_t), .swapped_o(swapped), .lent_o(lent)
  );

  swap_share #(.NPORT(NPORT), .IDXW(IDXW)) u_share (
    .clk(clk), .rst_n(rst_n), .lent_i(lent), .guest_i(guest_t),
    .freeze_i(freeze), .load_i(load), .occ_zero_i(occ_zero),
    .tail_i(tail_out_i), .up_req_i(up_req_i), .guest_own_o(guest_own)
  );

  swap_hold #(.NPORT(NPORT)) u_hold (
    .clk(clk), .rst_n(rst_n), .tok_i(ctl_tok_i), .ds_grant_i(ds_grant_i),
    .tx_ok_o(tx_ok_o)
  );

  for (genvar p = 0; p < NPORT; p++) begin : g_out
    always_comb begin
      if ((st == SW_DRAIN) && ((fr == IDXW'(p)) || (br == IDXW'(p))))
        grant_o[p] = 1'b0;
      else if (fault_i[p] && !swapped[p])
        grant_o[p] = 1'b0;
      else if (swapped[p])
        grant_o[p] = guest_own[map_t[p]];
      else if (lent[p])
        grant_o[p] = !guest_own[p];
      else
        grant_o[p] = 1'b1;
    end
    assign port_ok_o[p] = !fault_i[p] || swapped[p];
    assign ctl_tok_o[p] = (st == SW_DRAIN) && first && (br == IDXW'(p));
  end

  assign map_o   = map_t;
  assign nosub_o = (st == SW_IDLE) && pend && !found;
  assign state_o = st;
endmodule

// File: rtl/buf_swap_chk.sv
module buf_swap_chk #(
  parameter int NPORT = 5,
  parameter int IDXW  = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NPORT-1:0]      fault_i,
  input logic [NPORT-1:0]      ctl_tok_i,
  input logic [NPORT-1:0]      ds_grant_i,
  input logic [NPORT*IDXW-1:0] map_o,
  input logic [NPORT-1:0]      grant_o,
  input logic [NPORT-1:0]      ctl_tok_o,
  input logic [NPORT-1:0]      tx_ok_o,
  input logic                  nosub_o,
  input logic [1:0]            state_o
);
  // R2
  tok_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ctl_tok_o));
  // R2
  tok_in_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_tok_o != '0) |-> (state_o == 2'd1));
  // R3
  nosub_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nosub_o |-> (state_o == 2'd0) && (ctl_tok_o == '0));
  // R5
  drain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd1) |=> (state_o == 2'd1) || (state_o == 2'd2));
  // R6
  engage_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd2) |=> (state_o == 2'd2) || (state_o == 2'd0));
  // R2
  idle_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_o == 2'd0) |=> (state_o == 2'd0) || (state_o == 2'd1));
  // R9
  tok_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_tok_i != '0) |=> ((tx_ok_o & $past(ctl_tok_i)) == '0));
  // R9
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_ok_o & ~ds_grant_i) == '0);

  for (genvar p = 0; p < NPORT; p++) begin : g_p
    logic [IDXW-1:0] mp;
    assign mp = map_o[p*IDXW +: IDXW];
    // R4
    pend_nogrant_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fault_i[p] && (mp == IDXW'(p))) |-> !grant_o[p]);
    // R6
    map_healthy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mp != IDXW'(p)) |-> !fault_i[mp]);
    for (genvar q = p + 1; q < NPORT; q++) begin : g_q
      // R7
      excl_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mp == map_o[q*IDXW +: IDXW]) |-> !(grant_o[p] && grant_o[q]));
    end
  end
endmodule

bind buf_swap_ctrl buf_swap_chk #(.NPORT(NPORT), .IDXW(IDXW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .ctl_tok_i(ctl_tok_i),
  .ds_grant_i(ds_grant_i), .map_o(map_o), .grant_o(grant_o),
  .ctl_tok_o(ctl_tok_o), .tx_ok_o(tx_ok_o), .nosub_o(nosub_o),
  .state_o(state_o)
);

// File: tb/buf_swap_ctrl_tb.sv
module buf_swap_ctrl_tb;
  localparam int N = 5;
  localparam int OW = 4;
  localparam int IW = 3;

  logic clk = 1'b0;
  logic rst_n;
  logic [N-1:0] fault_i, tail_out_i, up_req_i, ctl_tok_i, ds_grant_i;
  logic [N*OW-1:0] occ_i;
  logic [N*IW-1:0] map_o;
  logic [N-1:0] grant_o, port_ok_o, ctl_tok_o, tx_ok_o;
  logic nosub_o;
  logic [1:0] state_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference model state
  int  m_st, m_fr, m_br, m_first;
  int  m_map[N];
  int  m_guest[N];
  bit  m_sw[N], m_lent[N], m_own[N], m_hold[N];

  always #5 clk = ~clk;

  buf_swap_ctrl #(.NPORT(N), .OCCW(OW)) u_dut (
    .clk(clk), .rst_n(rst_n), .fault_i(fault_i), .occ_i(occ_i),
    .tail_out_i(tail_out_i), .up_req_i(up_req_i), .ctl_tok_i(ctl_tok_i),
    .ds_grant_i(ds_grant_i), .map_o(map_o), .grant_o(grant_o),
    .port_ok_o(port_ok_o), .ctl_tok_o(ctl_tok_o), .tx_ok_o(tx_ok_o),
    .nosub_o(nosub_o), .state_o(state_o)
  );

  function automatic int occ(int b);
    return int'(occ_i[b*OW +: OW]);
  endfunction

  task automatic model_reset();
    m_st = 0; m_fr = 0; m_br = 0; m_first = 0;
    for (int p = 0; p < N; p++) begin
      m_map[p] = p; m_guest[p] = 0; m_sw[p] = 0; m_lent[p] = 0;
      m_own[p] = 0; m_hold[p] = 0;
    end
  endtask

  function automatic int pend_port();
    for (int p = 0; p < N; p++) if (fault_i[p] && !m_sw[p]) return p;
    return -1;
  endfunction

  function automatic int find_sub(int f);
    for (int k = 1; k < N; k++) begin
      int c = (f + k) % N;
      if (!fault_i[c] && !m_lent[c] && !m_sw[c]) return c;
    end
    return -1;
  endfunction

  task automatic model_step();
    int  f, s, nst, nfirst;
    bit  nown[N];
    bit  eng;
    f = pend_port();
    s = (f >= 0) ? find_sub(f) : -1;
    nst = m_st; nfirst = 0; eng = 0;
    for (int b = 0; b < N; b++) begin
      nown[b] = m_own[b];
      if (m_lent[b] && !(m_st != 0 && b == m_br) && occ(b) == 0) begin
        int g = m_guest[b];
        if (m_own[b] && up_req_i[b] && (tail_out_i[b] || !up_req_i[g])) nown[b] = 0;
        else if (!m_own[b] && up_req_i[g] && (tail_out_i[b] || !up_req_i[b])) nown[b] = 1;
      end
    end
    for (int p = 0; p < N; p++) begin
      if (ctl_tok_i[p]) m_hold[p] = 1;
      else if (!ds_grant_i[p]) m_hold[p] = 0;
    end
    if (m_st == 0) begin
      if (s >= 0) begin nst = 1; nfirst = 1; m_fr = f; m_br = s; end
    end else if (m_st == 1) begin
      if (occ(m_br) == 0 && (tail_out_i[m_br] || m_first != 0)) begin
        nst = 2; eng = 1;
      end
    end else begin
      if (occ(m_br) == 0 && (tail_out_i[m_br] || !up_req_i[m_fr])) nst = 0;
    end
    for (int b = 0; b < N; b++) m_own[b] = nown[b];
    if (eng) begin
      m_map[m_fr] = m_br; m_sw[m_fr] = 1; m_lent[m_br] = 1;
      m_guest[m_br] = m_fr; m_own[m_br] = 1;
    end
    m_st = nst; m_first = nfirst;
  endtask

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    int e_grant, e_ok, e_tok, e_tx, e_map, e_nosub, f;
    e_grant = 0; e_ok = 0; e_tok = 0; e_tx = 0; e_map = 0;
    for (int p = 0; p < N; p++) begin
      bit g;
      if (m_st == 1 && (p == m_fr || p == m_br)) g = 0;
      else if (fault_i[p] && !m_sw[p]) g = 0;
      else if (m_sw[p]) g = m_own[m_map[p]];
      else if (m_lent[p]) g = !m_own[p];
      else g = 1;
      e_grant |= int'(g) << p;
      if (!fault_i[p] || m_sw[p]) e_ok |= 1 << p;
      if (ds_grant_i[p] && !m_hold[p]) e_tx |= 1 << p;
      e_map |= m_map[p] << (p * IW);
    end
    if (m_st == 1 && m_first != 0) e_tok = 1 << m_br;
    f = pend_port();
    e_nosub = (m_st == 0 && f >= 0 && find_sub(f) < 0) ? 1 : 0;
    chk("R4/R7", "grant_o", int'(grant_o), e_grant);
    chk("R8", "port_ok_o", int'(port_ok_o), e_ok);
    chk("R2", "ctl_tok_o", int'(ctl_tok_o), e_tok);
    chk("R9", "tx_ok_o", int'(tx_ok_o), e_tx);
    chk("R6", "map_o", int'(map_o), e_map);
    chk("R3", "nosub_o", int'(nosub_o), e_nosub);
    chk("R5", "state_o", int'(state_o), m_st);
  endtask

  task automatic randomize_io();
    for (int p = 0; p < N; p++) begin
      occ_i[p*OW +: OW] = OW'($urandom_range(0, 3));
      tail_out_i[p] = ($urandom_range(0, 9) < 3);
      up_req_i[p]   = ($urandom_range(0, 9) < 6);
      ctl_tok_i[p]  = ($urandom_range(0, 19) == 0);
      ds_grant_i[p] = ($urandom_range(0, 9) < 8);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare();
      randomize_io();
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fault_i = '0; occ_i = '0; tail_out_i = '0; up_req_i = '0;
    ctl_tok_i = '0; ds_grant_i = '1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    model_reset();
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : stim
    do_reset();
    // R1: reset state seen at the ports
    chk("R1", "map_o", int'(map_o), 'h4688);
    chk("R1", "state_o", int'(state_o), 0);
    chk("R1", "grant_o", int'(grant_o), 'h1f);
    chk("R1", "ctl_tok_o", int'(ctl_tok_o), 0);
    chk("R1", "nosub_o", int'(nosub_o), 0);
    step(40);
    // R2 R5 R6 R7: north fails, east buffer substitutes
    fault_i[0] = 1'b1;
    step(200);
    chk("R6", "map[0] after swap", int'(map_o[0 +: IW]), 1);
    // west fails, local buffer substitutes
    fault_i[3] = 1'b1;
    step(200);
    chk("R6", "map[3] after swap", int'(map_o[3*IW +: IW]), 4);
    // R3: south fails, every other buffer faulty or lent
    fault_i[2] = 1'b1;
    step(60);
    chk("R3", "nosub_o with no candidate", int'(nosub_o), 1);
    chk("R3", "state_o stays idle", int'(state_o), 0);
    // R10: two faults at once, lower index serviced first
    do_reset();
    fault_i[1] = 1'b1; fault_i[3] = 1'b1;
    @(posedge clk); model_step(); @(negedge clk);
    compare();
    chk("R10", "first token goes to buffer 2", int'(ctl_tok_o), 'h04);
    randomize_io();
    step(300);
    chk("R10", "map[1]", int'(map_o[1*IW +: IW]), 2);
    chk("R10", "map[3]", int'(map_o[3*IW +: IW]), 4);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule